// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block takes a processor from normal execution into its exception handler. A one-cycle request comes in with either a direct cause code or the result of a failed address translation. On that request the block records where execution must later resume, writes the cause code, and on translation faults captures the faulting address in three fault registers. It also computes the address of the handler. One cycle after the request it presents that address with a one-cycle redirect strobe, and the fetch unit restarts from there.

Software-visible control is read from inputs: the boot-vector select, the vectored-interrupt select, the exception base and the current address-space identifier. The exception-level flag is held inside the block. Every request sets it, and a return strobe clears it. While the flag is set, nested exceptions still update the cause code and the handler address. The saved resume address and the delay-slot marker are left as they are.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous active-low reset, every output reads zero: resume address, cause word, level flag, fault address, context, entry-high, redirect strobe and handler address.
- R2: For a request with `xlat_fault_i` low, `exc_code_i` appears in cause bits 6:2 on the cycle after the request. The cause word changes only on a request.
- R3: For a request with `xlat_fault_i` high, `xlat_res_i` selects the code: 0 (no match) or 1 (invalid) gives 2 for loads and 3 for stores; 2 (dirty) gives 1; 3 (bad address) gives 4 for loads and 5 for stores. `is_store_i` high marks a store.
- R4: A request taken with the level flag clear saves `pc_i` as the resume address and clears cause bit 31. When `in_delay_slot_i` is high, it saves `pc_i`−4 and sets bit 31 instead. In both cases the level flag is set.
- R5: A request taken with the level flag already set leaves the resume address and cause bit 31 unchanged. It still writes the code.
- R6: The handler base is 0xBFC00200 when `boot_vec_i` is high. Otherwise it is `ebase_i` with bits 9:0 forced to zero.
- R7: The handler address is base + 0x180 by default. It is base + 0x200 for code 0 with `int_vec_i` high. It is base + 0x000 for a no-match translation fault taken with the level flag clear.
- R8: A translation fault loads `fault_addr_i` into the fault-address output and writes address bits 31:13 into context bits 22:4. It also loads entry-high with address bits 31:13 in bits 31:13, zero in bits 12:8 and `asid_i` in bits 7:0. Other requests leave all three unchanged.
- R9: A request whose resulting code is 11 writes `cop_num_i` into cause bits 29:28. Any other code leaves those bits unchanged.
- R10: `redirect_o` is high for exactly the cycle after each request, and `new_pc_o` holds the last computed handler address.
- R11: `eret_i` without a request clears the level flag on the next cycle. A request in the same cycle takes precedence and sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| exc_req_i | input | 1 | One-cycle exception request |
| exc_code_i | input | 5 | Cause code for non-translation requests |
| xlat_fault_i | input | 1 | Request comes from a translation fault |
| xlat_res_i | input | 2 | Translation result: 0 no match, 1 invalid, 2 dirty, 3 bad address |
| is_store_i | input | 1 | Faulting access was a store |
| cop_num_i | input | 2 | Coprocessor number for code 11 |
| pc_i | input | 32 | Address of the faulting instruction |
| in_delay_slot_i | input | 1 | Faulting instruction sits in a branch delay slot |
| fault_addr_i | input | 32 | Faulting data or fetch address |
| asid_i | input | 8 | Current address-space identifier |
| boot_vec_i | input | 1 | Use the boot handler base |
| int_vec_i | input | 1 | Use the separate interrupt offset |
| ebase_i | input | 32 | Exception base |
| eret_i | input | 1 | Return from exception, clears the level flag |
| epc_o | output | 32 | Saved resume address |
| cause_o | output | 32 | Cause word: bit 31 delay slot, 29:28 coprocessor, 6:2 code |
| exl_o | output | 1 | Exception-level flag |
| badvaddr_o | output | 32 | Last faulting translation address |
| context_o | output | 32 | Context word, page-pair number in bits 22:4 |
| entryhi_o | output | 32 | Entry-high word |
| redirect_o | output | 1 | Fetch redirect strobe |
| new_pc_o | output | 32 | Handler address |

## Verification
All results of a request are due at once, one clock edge after the request is sampled. This covers the resume address, cause word, level flag, fault registers, handler address and strobe. The level flag the request sees, and so its offset and whether the resume address is saved, is the value from before that edge. The bench drives inputs on the falling edge and compares every output with its model on the next falling edge, so every comparison falls exactly one register stage after its stimulus. Directed cases against fixed constants cover nested entry, return, and a return arriving together with a request.

// File: rtl/exc_entry_pkg.sv
// Package: shared encodings for the exception entry unit.
// Assumes a 5-bit cause code and a 2-bit translation result.
package exc_entry_pkg;

    localparam int CODE_W = 5;

    // Cause word field positions decoded by software.
    localparam int CAUSE_EC_LSB = 2;
    localparam int CAUSE_CE_LSB = 28;
    localparam int CAUSE_BD_BIT = 31;

    typedef enum logic [1:0] {
        XR_NOMATCH = 2'd0,
        XR_INVALID = 2'd1,
        XR_DIRTY   = 2'd2,
        XR_BADADDR = 2'd3
    } xlat_res_e;

    localparam logic [CODE_W-1:0] CODE_INT    = 5'd0;
    localparam logic [CODE_W-1:0] CODE_TLBMOD = 5'd1;
    localparam logic [CODE_W-1:0] CODE_TLBLD  = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBST  = 5'd3;
    localparam logic [CODE_W-1:0] CODE_ADRLD  = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ADRST  = 5'd5;
    localparam logic [CODE_W-1:0] CODE_COPUN  = 5'd11;

    // Result of classifying one request.
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              refill;
        logic              xlat;
    } exc_class_t;

endpackage

// File: rtl/exc_classify.sv
// Module: exc_classify
// Turns a request into a final cause code, a refill marker and a
// translation-fault marker. Purely combinational; the result is only
// meaningful while a request is present.
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic              xlat_fault_i,
    input  logic [1:0]        xlat_res_i,
    input  logic              is_store_i,
    input  logic [CODE_W-1:0] code_i,
    output exc_class_t        cls_o
);

    // Map translation results to codes, or pass the direct code through.
    always_comb begin
        cls_o.code   = code_i;
        cls_o.refill = 1'b0;
        cls_o.xlat   = xlat_fault_i;
        if (xlat_fault_i) begin
            unique case (xlat_res_e'(xlat_res_i))
                XR_NOMATCH: begin
                    cls_o.code   = is_store_i ? CODE_TLBST : CODE_TLBLD;
                    cls_o.refill = 1'b1;
                end
                XR_INVALID: cls_o.code = is_store_i ? CODE_TLBST : CODE_TLBLD;
                XR_DIRTY:   cls_o.code = CODE_TLBMOD;
                default:    cls_o.code = is_store_i ? CODE_ADRST : CODE_ADRLD;
            endcase
        end
    end

endmodule

// File: rtl/exc_vector.sv
// Module: exc_vector
// Computes the handler address from the classified request, the current
// exception-level flag (before this request sets it) and the base controls.
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              BASE_ALIGN = 10,
    parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] OFS_GEN    = 32'h0000_0180,
    parameter logic [XLEN-1:0] OFS_IRQ    = 32'h0000_0200,
    parameter logic [XLEN-1:0] OFS_REFILL = 32'h0000_0000
) (
    input  exc_class_t      cls_i,
    input  logic            exl_i,
    input  logic            boot_vec_i,
    input  logic            int_vec_i,
    input  logic [XLEN-1:0] ebase_i,
    output logic [XLEN-1:0] target_o
);

    localparam logic [XLEN-1:0] ALIGN_MASK =
        ~((XLEN'(1) << BASE_ALIGN) - XLEN'(1));

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Pick the handler base.
    always_comb begin
        base = boot_vec_i ? BOOT_BASE : (ebase_i & ALIGN_MASK);
    end

    // Pick the offset: the interrupt and refill cases override the default.
    always_comb begin
        if (cls_i.code == CODE_INT && !cls_i.xlat && int_vec_i)
            offset = OFS_IRQ;
        else if (cls_i.refill && !exl_i)
            offset = OFS_REFILL;
        else
            offset = OFS_GEN;
    end

    // Form the handler address.
    always_comb begin
        target_o = base + offset;
    end

endmodule

// File: rtl/exc_state_regs.sv
// Module: exc_state_regs
// Holds the architectural state written on exception entry: level flag,
// resume address, cause fields, fault registers and the redirect pair.
// Assumes 4 KiB pages, so a page pair starts at bit PAGE_SHIFT+1.
module exc_state_regs
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int CTX_LSB    = 4,
    parameter int COP_W      = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              eret_i,
    input  exc_class_t        cls_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              in_ds_i,
    input  logic [COP_W-1:0]  cop_i,
    input  logic [XLEN-1:0]   fault_addr_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [XLEN-1:0]   target_i,
    output logic              exl_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   badv_o,
    output logic [XLEN-1:0]   ctx_o,
    output logic [XLEN-1:0]   ehi_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   new_pc_o
);

    localparam int VPN2_LSB = PAGE_SHIFT + 1;
    localparam int VPN2_W   = XLEN - VPN2_LSB;
    localparam int GAP_W    = VPN2_LSB - ASID_W;

    logic              exl_q;
    logic              bd_q;
    logic [XLEN-1:0]   epc_q;
    logic [CODE_W-1:0] code_q;
    logic [COP_W-1:0]  ce_q;
    logic [XLEN-1:0]   badv_q;
    logic [VPN2_W-1:0] ctx_vpn_q;
    logic [XLEN-1:0]   ehi_q;
    logic              redir_q;
    logic [XLEN-1:0]   npc_q;

    // Level flag: set by any request, cleared by a lone return.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      exl_q <= 1'b0;
        else if (req_i)   exl_q <= 1'b1;
        else if (eret_i)  exl_q <= 1'b0;
    end

    // Resume address and delay-slot marker, written only from level zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            epc_q <= '0;
            bd_q  <= 1'b0;
        end else if (req_i && !exl_q) begin
            epc_q <= in_ds_i ? (pc_i - XLEN'(4)) : pc_i;
            bd_q  <= in_ds_i;
        end
    end

    // Cause code, written on every request.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    code_q <= '0;
        else if (req_i) code_q <= cls_i.code;
    end

    // Coprocessor number, written only for the coprocessor-unusable code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                                 ce_q <= '0;
        else if (req_i && cls_i.code == CODE_COPUN)  ce_q <= cop_i;
    end

    // Fault registers, written only on translation faults.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            badv_q    <= '0;
            ctx_vpn_q <= '0;
            ehi_q     <= '0;
        end else if (req_i && cls_i.xlat) begin
            badv_q    <= fault_addr_i;
            ctx_vpn_q <= fault_addr_i[XLEN-1:VPN2_LSB];
            ehi_q     <= {fault_addr_i[XLEN-1:VPN2_LSB], {GAP_W{1'b0}}, asid_i};
        end
    end

    // Redirect strobe and held handler address.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            redir_q <= 1'b0;
            npc_q   <= '0;
        end else begin
            redir_q <= req_i;
            if (req_i) npc_q <= target_i;
        end
    end

    // Assemble the cause word from its fields.
    always_comb begin
        cause_o = '0;
        cause_o[CAUSE_BD_BIT]                = bd_q;
        cause_o[CAUSE_CE_LSB +: COP_W]       = ce_q;
        cause_o[CAUSE_EC_LSB +: CODE_W]      = code_q;
    end

    // Assemble the context word from the page-pair field.
    always_comb begin
        ctx_o = '0;
        ctx_o[CTX_LSB +: VPN2_W] = ctx_vpn_q;
    end

    // Drive the remaining outputs from their registers.
    always_comb begin
        exl_o      = exl_q;
        epc_o      = epc_q;
        badv_o     = badv_q;
        ehi_o      = ehi_q;
        redirect_o = redir_q;
        new_pc_o   = npc_q;
    end

endmodule

// File: rtl/exc_entry_unit.sv
// Module: exc_entry_unit (top)
// Exception entry: classifies a one-cycle request, computes the handler
// address from the pre-request level flag and updates entry state. All
// results appear one cycle after the request.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int COP_W      = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              exc_req_i,
    input  logic [4:0]        exc_code_i,
    input  logic              xlat_fault_i,
    input  logic [1:0]        xlat_res_i,
    input  logic              is_store_i,
    input  logic [COP_W-1:0]  cop_num_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              in_delay_slot_i,
    input  logic [XLEN-1:0]   fault_addr_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic              boot_vec_i,
    input  logic              int_vec_i,
    input  logic [XLEN-1:0]   ebase_i,
    input  logic              eret_i,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic              exl_o,
    output logic [XLEN-1:0]   badvaddr_o,
    output logic [XLEN-1:0]   context_o,
    output logic [XLEN-1:0]   entryhi_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   new_pc_o
);

    exc_class_t      cls;
    logic [XLEN-1:0] target;

    exc_classify u_classify (
        .xlat_fault_i (xlat_fault_i),
        .xlat_res_i   (xlat_res_i),
        .is_store_i   (is_store_i),
        .code_i       (exc_code_i),
        .cls_o        (cls)
    );

    exc_vector #(
        .XLEN (XLEN)
    ) u_vector (
        .cls_i      (cls),
        .exl_i      (exl_o),
        .boot_vec_i (boot_vec_i),
        .int_vec_i  (int_vec_i),
        .ebase_i    (ebase_i),
        .target_o   (target)
    );

    exc_state_regs #(
        .XLEN       (XLEN),
        .ASID_W     (ASID_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .COP_W      (COP_W)
    ) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (exc_req_i),
        .eret_i       (eret_i),
        .cls_i        (cls),
        .pc_i         (pc_i),
        .in_ds_i      (in_delay_slot_i),
        .cop_i        (cop_num_i),
        .fault_addr_i (fault_addr_i),
        .asid_i       (asid_i),
        .target_i     (target),
        .exl_o        (exl_o),
        .epc_o        (epc_o),
        .cause_o      (cause_o),
        .badv_o       (badvaddr_o),
        .ctx_o        (context_o),
        .ehi_o        (entryhi_o),
        .redirect_o   (redirect_o),
        .new_pc_o     (new_pc_o)
    );

endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Temporal checks on the exception entry unit, bound to its ports.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            exc_req_i,
    input logic            eret_i,
    input logic            xlat_fault_i,
    input logic [4:0]      exc_code_i,
    input logic [XLEN-1:0] epc_o,
    input logic [XLEN-1:0] cause_o,
    input logic            exl_o,
    input logic [XLEN-1:0] badvaddr_o,
    input logic            redirect_o
);

    // R10
    redirect_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i |=> redirect_o);

    // R10
    redirect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc_req_i |=> !redirect_o);

    // R4
    level_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i |=> exl_o);

    // R5
    epc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && exl_o) |=> $stable(epc_o));

    // R11
    level_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eret_i && !exc_req_i) |=> !exl_o);

    // R2
    code_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && !xlat_fault_i) |=>
            cause_o[CAUSE_EC_LSB +: CODE_W] == $past(exc_code_i));

    // R2
    cause_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc_req_i |=> $stable(cause_o));

    // R8
    badv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && !xlat_fault_i) |=> $stable(badvaddr_o));

endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 0, eret = 0, xf = 0, st = 0, ds = 0, bev = 0, iv = 0;
    logic [4:0]  code = 0;
    logic [1:0]  res = 0, cop = 0;
    logic [31:0] pc = 0, addr = 0, ebase = 0;
    logic [7:0]  asid = 0;

    logic [31:0] epc, cause, badv, ctx, ehi, npc;
    logic        exl, redir;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    exc_entry_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .exc_code_i(code),
        .xlat_fault_i(xf), .xlat_res_i(res), .is_store_i(st), .cop_num_i(cop),
        .pc_i(pc), .in_delay_slot_i(ds), .fault_addr_i(addr), .asid_i(asid),
        .boot_vec_i(bev), .int_vec_i(iv), .ebase_i(ebase), .eret_i(eret),
        .epc_o(epc), .cause_o(cause), .exl_o(exl), .badvaddr_o(badv),
        .context_o(ctx), .entryhi_o(ehi), .redirect_o(redir), .new_pc_o(npc)
    );

    // Reference model state
    logic [31:0] m_epc, m_badv, m_ctx, m_ehi, m_npc, m_base, m_ofs;
    logic        m_bd, m_exl, m_redir, m_refill;
    logic [1:0]  m_ce;
    logic [4:0]  m_code, m_c;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_epc = 0; m_badv = 0; m_ctx = 0; m_ehi = 0; m_npc = 0;
            m_bd = 0; m_exl = 0; m_redir = 0; m_ce = 0; m_code = 0;
        end else begin
            m_redir = req;
            if (req) begin
                m_refill = 0;
                m_c = code;
                if (xf) begin
                    if (res == 2'd0 || res == 2'd1) m_c = st ? 5'd3 : 5'd2;
                    else if (res == 2'd2) m_c = 5'd1;
                    else m_c = st ? 5'd5 : 5'd4;
                    m_refill = (res == 2'd0);
                end
                m_base = bev ? 32'hBFC00200 : {ebase[31:10], 10'd0};
                if (m_c == 0 && !xf && iv) m_ofs = 32'h200;
                else if (m_refill && !m_exl) m_ofs = 32'h0;
                else m_ofs = 32'h180;
                m_npc = m_base + m_ofs;
                if (!m_exl) begin
                    m_epc = ds ? pc - 32'd4 : pc;
                    m_bd  = ds;
                end
                m_exl = 1;
                m_code = m_c;
                if (m_c == 5'd11) m_ce = cop;
                if (xf) begin
                    m_badv = addr;
                    m_ctx  = {9'd0, addr[31:13], 4'd0};
                    m_ehi  = {addr[31:13], 5'd0, asid};
                end
            end else if (eret) begin
                m_exl = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the model
    task automatic compare_all();
        chk("R4 resume address", epc, m_epc);
        chk("R4 delay-slot bit", {31'd0, cause[31]}, {31'd0, m_bd});
        chk("R2 R3 cause word", cause, {m_bd, 1'b0, m_ce, 21'd0, m_code, 2'd0});
        chk("R9 coprocessor field", {30'd0, cause[29:28]}, {30'd0, m_ce});
        chk("R4 level flag", {31'd0, exl}, {31'd0, m_exl});
        chk("R8 fault address", badv, m_badv);
        chk("R8 context", ctx, m_ctx);
        chk("R8 entry-high", ehi, m_ehi);
        chk("R10 redirect", {31'd0, redir}, {31'd0, m_redir});
        chk("R7 handler address", npc, m_npc);
    endtask

    task automatic tick();
        @(negedge clk);
        if (cmp_on) compare_all();
    endtask

    task automatic fire(input logic f, input logic [1:0] r, input logic s,
                        input logic [4:0] c, input logic [31:0] p, input logic d,
                        input logic [31:0] a);
        req = 1; xf = f; res = r; st = s; code = c; pc = p; ds = d; addr = a;
        tick();
        req = 0;
    endtask

    task automatic do_eret();
        eret = 1;
        tick();
        eret = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        // R1: reset values
        chk("R1 reset epc", epc, 0);
        chk("R1 reset cause", cause, 0);
        chk("R1 reset state", {exl, redir}, 0);
        chk("R1 reset fault regs", badv | ctx | ehi | npc, 0);

        // R2 R4 R6 R7: syscall from level zero, boot base
        bev = 1; iv = 0;
        fire(0, 0, 0, 5'd8, 32'h1000, 0, 0);
        chk("R4 epc from pc", epc, 32'h1000);
        chk("R2 code 8", {27'd0, cause[6:2]}, 8);
        chk("R6 R7 boot base + 0x180", npc, 32'hBFC00380);
        chk("R10 strobe high", {31'd0, redir}, 1);
        tick();
        chk("R10 strobe drops", {31'd0, redir}, 0);

        // R5 R8: nested break in delay slot keeps epc, bd and fault regs
        fire(0, 0, 0, 5'd9, 32'h2000, 1, 32'hDEAD0000);
        chk("R5 epc kept", epc, 32'h1000);
        chk("R5 bd kept", {31'd0, cause[31]}, 0);
        chk("R5 code still written", {27'd0, cause[6:2]}, 9);
        chk("R8 badv untouched", badv, 0);

        // R11: return clears level
        do_eret();
        chk("R11 level cleared", {31'd0, exl}, 0);

        // R4 R6: delay slot, aligned exception base
        bev = 0; ebase = 32'h80001234;
        fire(0, 0, 0, 5'd12, 32'h3000, 1, 0);
        chk("R4 epc pc-4", epc, 32'h2FFC);
        chk("R4 bd set", {31'd0, cause[31]}, 1);
        chk("R6 ebase aligned", npc, 32'h80001180);
        do_eret();

        // R3 R7 R8: refill load at level zero
        ebase = 32'h80000000; asid = 8'h5A;
        fire(1, 2'd0, 0, 5'd0, 32'h4000, 0, 32'h12345678);
        chk("R3 no-match load code", {27'd0, cause[6:2]}, 2);
        chk("R7 refill offset 0", npc, 32'h80000000);
        chk("R8 badv", badv, 32'h12345678);
        chk("R8 context", ctx, 32'h00091A20);
        chk("R8 entry-high", ehi, 32'h1234405A);

        // R7: refill store at level one uses general offset
        fire(1, 2'd0, 1, 5'd0, 32'h4100, 0, 32'hC0002000);
        chk("R3 no-match store code", {27'd0, cause[6:2]}, 3);
        chk("R7 nested refill offset", npc, 32'h80000180);
        do_eret();

        // R3: remaining translation results
        fire(1, 2'd2, 1, 5'd0, 32'h10, 0, 32'h100); do_eret();
        chk("R3 dirty code", {27'd0, cause[6:2]}, 1);
        fire(1, 2'd1, 0, 5'd0, 32'h20, 0, 32'h200);
        chk("R3 invalid load code", {27'd0, cause[6:2]}, 2);
        chk("R7 invalid offset", npc, 32'h80000180);
        do_eret();
        fire(1, 2'd3, 1, 5'd0, 32'h30, 0, 32'h300); do_eret();
        chk("R3 bad store code", {27'd0, cause[6:2]}, 5);
        fire(1, 2'd3, 0, 5'd0, 32'h40, 0, 32'h400); do_eret();
        chk("R3 bad load code", {27'd0, cause[6:2]}, 4);

        // R7: interrupt offsets
        iv = 1;
        fire(0, 0, 0, 5'd0, 32'h50, 0, 0); do_eret();
        chk("R7 vectored interrupt", npc, 32'h80000200);
        iv = 0;
        fire(0, 0, 0, 5'd0, 32'h60, 0, 0); do_eret();
        chk("R7 plain interrupt", npc, 32'h80000180);

        // R9: coprocessor field
        cop = 2'd2;
        fire(0, 0, 0, 5'd11, 32'h70, 0, 0); do_eret();
        chk("R9 ce written", {30'd0, cause[29:28]}, 2);
        cop = 2'd3;
        fire(0, 0, 0, 5'd8, 32'h80, 0, 0); do_eret();
        chk("R9 ce kept", {30'd0, cause[29:28]}, 2);

        // R11: return together with request
        eret = 1;
        fire(0, 0, 0, 5'd13, 32'h90, 0, 0);
        eret = 0;
        chk("R11 request wins", {31'd0, exl}, 1);
        do_eret();

        // Mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            req = ($urandom % 3) == 0; eret = ($urandom % 4) == 0;
            xf = $urandom; res = $urandom; st = $urandom; code = $urandom;
            cop = $urandom; pc = $urandom; ds = $urandom; addr = $urandom;
            asid = $urandom; bev = $urandom; iv = $urandom; ebase = $urandom;
            tick();
        end
        req = 0; eret = 0;
        tick();
        finish_run();
    end

endmodule